// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt inputs, ranks them with a fixed priority (input 0 first), and raises one interrupt line toward the processor. Software programs it through a byte-wide port that has two addresses. The command address starts initialization, issues end-of-interrupt commands, and chooses which status register the command address returns on a read. The data address receives the initialization words and, outside initialization, holds the mask register.

When the processor pulses the acknowledge input, the block picks the winning request, moves it from the request register into the in-service register, and one cycle later presents an 8-bit vector: the programmed base plus the input number. If no request is eligible at that moment, the block returns the vector for input 7 and changes no in-service state. A build-time parameter sets master or slave behaviour. A master that acknowledges an input with a slave behind it places the input number on a 3-bit cascade bus instead of a vector. A slave answers an acknowledge only when the cascade select is active and the bus carries its own identity.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, the mask register reads 0x00, the request and in-service registers are clear, `cpu_int` is low, and command-address reads return the request register.
- R2: A command write of 0x11 starts initialization. It clears the mask, request and in-service registers and selects the request register for reads. The next three data writes are init words 2, 3 and 4. On an acknowledge that is not redirected, the vector equals word 2 plus the input number.
- R3: Priority is fixed with input 0 highest. `cpu_int` is high only when some unmasked request has higher priority than every bit set in the in-service register.
- R4: Outside initialization, a data write loads the mask register and a data read returns it. A masked input never raises `cpu_int`.
- R5: A request bit sets on a rising edge of its input. It clears when that input goes low, and it clears when an acknowledge takes it into service.
- R6: A command write of 0x0B makes later command reads return the in-service register, and 0x0A makes them return the request register. The choice persists until it is changed.
- R7: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R8: An acknowledge with no eligible request yields vector base+7 and leaves the in-service register unchanged. This holds even when input 7 is masked.
- R9: When bit 1 of init word 4 is set (auto end-of-interrupt), an acknowledge sets no in-service bit.
- R10: In a master, if init word 3 has the bit of the winning input set, the acknowledge drives that input number on `cas_id` with `cas_en` high for one cycle and gives no vector. The in-service bit is still set.
- R11: In a slave, an acknowledge takes effect only when `cas_sel` is high and `cas_in` equals bits 2:0 of init word 3. Otherwise the acknowledge changes no state and yields no vector.
- R12: `vec_valid` and `cas_en` pulse in the cycle after the acknowledge, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_in | input | 8 | Interrupt request inputs |
| ack | input | 1 | Interrupt acknowledge pulse |
| cas_sel | input | 1 | Slave only: cascade bus carries a valid selection |
| cas_in | input | 3 | Slave only: cascade identity from the master |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector present on `vec` |
| vec | output | 8 | Interrupt vector |
| cas_en | output | 1 | Master only: cascade number present |
| cas_id | output | 3 | Master only: cascade input number |

## Verification
Several properties are checked on every cycle by the assertions. `cpu_int` is never raised without an unmasked request. A specific end-of-interrupt really clears its bit. An acknowledge removes the taken request. A spurious acknowledge and an auto end-of-interrupt acknowledge leave the in-service register without new bits. A vector and a cascade number never appear together.

Other behaviour only the bench scenarios can show. These are the actual vector values, the nesting order under an active in-service bit, and the persistence of the read selection. They also cover the request that vanishes before acknowledge, and the master and slave sides of a cascade.

// File: rtl/irc_pkg.sv
package irc_pkg;
    localparam int NIN = 8;
    localparam int IDW = $clog2(NIN);

    localparam logic [7:0] CMD_INIT   = 8'h11;
    localparam logic [7:0] CMD_RD_IRR = 8'h0A;
    localparam logic [7:0] CMD_RD_ISR = 8'h0B;
    localparam logic [4:0] EOI_OP     = 5'b01100;

    typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_e;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] casc;
        logic       aeoi;
    } irc_cfg_t;

    typedef struct packed {
        logic           vld;
        logic [IDW-1:0] idx;
    } eoi_t;

    function automatic logic [NIN-1:0] allow_below(input logic [NIN-1:0] isr);
        logic [NIN-1:0] r;
        for (int i = 0; i < NIN; i++) begin
            r[i] = ((isr & ((NIN'(2) << i) - NIN'(1))) == '0);
        end
        return r;
    endfunction

    function automatic logic [IDW-1:0] first_set(input logic [NIN-1:0] v);
        logic [IDW-1:0] r;
        r = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (v[i]) r = IDW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irc_prog.sv
module irc_prog
    import irc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           addr,
    input  logic [7:0]     wdata,
    output irc_cfg_t       cfg,
    output logic [NIN-1:0] imr,
    output logic           rsel_isr,
    output eoi_t           eoi,
    output logic           init_pulse
);
    init_st_e st;
    logic     cmd_wr, dat_wr;

    assign cmd_wr     = wr_en && !addr;
    assign dat_wr     = wr_en && addr;
    assign init_pulse = cmd_wr && (wdata == CMD_INIT);
    assign eoi.vld    = cmd_wr && (wdata[7:3] == EOI_OP);
    assign eoi.idx    = wdata[IDW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_RUN;
            imr      <= '0;
            rsel_isr <= 1'b0;
            cfg      <= '0;
        end else if (init_pulse) begin
            st       <= ST_W2;
            imr      <= '0;
            rsel_isr <= 1'b0;
        end else if (cmd_wr) begin
            if (wdata == CMD_RD_IRR) rsel_isr <= 1'b0;
            else if (wdata == CMD_RD_ISR) rsel_isr <= 1'b1;
        end else if (dat_wr) begin
            unique case (st)
                ST_W2: begin cfg.base <= wdata; st <= ST_W3; end
                ST_W3: begin cfg.casc <= wdata; st <= ST_W4; end
                ST_W4: begin cfg.aeoi <= wdata[1]; st <= ST_RUN; end
                default: imr <= wdata;
            endcase
        end
    end

    // R2: init word 2 is captured on the first data write after the start command
    p_init_base_r2: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && st == ST_W2 && !init_pulse) |=> (cfg.base == $past(wdata)));
endmodule

// File: rtl/irc_core.sv
module irc_core
    import irc_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] irq_in,
    input  logic [NIN-1:0] imr,
    input  irc_cfg_t       cfg,
    input  eoi_t           eoi,
    input  logic           init_pulse,
    input  logic           ack,
    input  logic           cas_sel,
    input  logic [IDW-1:0] cas_in,
    output logic [NIN-1:0] irr,
    output logic [NIN-1:0] isr,
    output logic           cpu_int,
    output logic           vec_valid,
    output logic [7:0]     vec,
    output logic           cas_en,
    output logic [IDW-1:0] cas_id
);
    logic [NIN-1:0] prev_in, pend, irr_n, isr_n;
    logic [IDW-1:0] win;
    logic           have, selected, take, to_cas;

    assign pend     = irr & ~imr & allow_below(isr);
    assign have     = |pend;
    assign win      = first_set(pend);
    assign cpu_int  = have;

    generate
        if (IS_MASTER) begin : g_master
            assign selected = 1'b1;
            assign to_cas   = have && cfg.casc[win];
        end else begin : g_slave
            assign selected = cas_sel && (cas_in == cfg.casc[IDW-1:0]);
            assign to_cas   = 1'b0;
        end
    endgenerate

    assign take = ack && selected;

    always_comb begin
        irr_n = (irr | (irq_in & ~prev_in)) & irq_in;
        isr_n = isr;
        if (eoi.vld) isr_n[eoi.idx] = 1'b0;
        if (take && have) begin
            irr_n[win] = 1'b0;
            if (!cfg.aeoi) isr_n[win] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_in <= '0;
        else     prev_in <= irq_in;
    end

    always_ff @(posedge clk) begin
        if (rst || init_pulse) begin
            irr       <= '0;
            isr       <= '0;
            vec_valid <= 1'b0;
            vec       <= '0;
            cas_en    <= 1'b0;
            cas_id    <= '0;
        end else begin
            irr       <= irr_n;
            isr       <= isr_n;
            vec_valid <= take && !to_cas;
            vec       <= cfg.base + (have ? 8'(win) : 8'(NIN - 1));
            cas_en    <= take && to_cas;
            cas_id    <= win;
        end
    end

    // R4: the processor line needs an unmasked request behind it
    p_int_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_int |-> ((irr & ~imr) != '0));
    // R7: a specific end-of-interrupt clears its bit
    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi.vld && !take) |=> !isr[$past(eoi.idx)]);
    // R5: a taken request leaves the request register
    p_take_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (take && have && !init_pulse) |=> !irr[$past(win)]);
    // R8: a spurious acknowledge leaves the in-service register alone
    p_spur_isr_r8: assert property (@(posedge clk) disable iff (rst)
        (take && !have && !eoi.vld && !init_pulse) |=> (isr == $past(isr)));
    // R9: auto end-of-interrupt adds no in-service bit
    p_aeoi_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg.aeoi && take) |=> ((isr & ~$past(isr)) == '0));
    // R12: vector and cascade number are exclusive
    p_vec_cas_excl_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vec_valid, cas_en}));
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irc_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] irq_in,
    input  logic       ack,
    input  logic       cas_sel,
    input  logic [2:0] cas_in,
    output logic       cpu_int,
    output logic       vec_valid,
    output logic [7:0] vec,
    output logic       cas_en,
    output logic [2:0] cas_id
);
    irc_cfg_t       cfg;
    eoi_t           eoi;
    logic [NIN-1:0] imr, irr, isr;
    logic           rsel_isr, init_pulse;

    irc_prog u_prog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg(cfg), .imr(imr), .rsel_isr(rsel_isr), .eoi(eoi),
        .init_pulse(init_pulse)
    );

    irc_core #(.IS_MASTER(IS_MASTER)) u_core (
        .clk(clk), .rst(rst), .irq_in(irq_in), .imr(imr), .cfg(cfg),
        .eoi(eoi), .init_pulse(init_pulse), .ack(ack), .cas_sel(cas_sel),
        .cas_in(cas_in), .irr(irr), .isr(isr), .cpu_int(cpu_int),
        .vec_valid(vec_valid), .vec(vec), .cas_en(cas_en), .cas_id(cas_id)
    );

    always_comb begin
        if (addr)          rdata = imr;
        else if (rsel_isr) rdata = isr;
        else               rdata = irr;
    end
endmodule

// File: tb/irq_ctrl8_bench.sv
module irq_ctrl8_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       m_wr = 0, m_addr = 0, m_ack = 0;
    logic [7:0] m_wdata = 0, m_irq = 0, m_rdata, m_vec;
    logic       m_int, m_vv, m_cen;
    logic [2:0] m_cid;

    logic       s_wr = 0, s_addr = 0, s_ack = 0, s_sel = 0;
    logic [2:0] s_cin = 0, s_cid;
    logic [7:0] s_wdata = 0, s_irq = 0, s_rdata, s_vec;
    logic       s_int, s_vv, s_cen;

    irq_ctrl8 #(.IS_MASTER(1'b1)) u_irq_ctrl8 (
        .clk(clk), .rst(rst), .wr_en(m_wr), .addr(m_addr), .wdata(m_wdata),
        .rdata(m_rdata), .irq_in(m_irq), .ack(m_ack), .cas_sel(1'b0),
        .cas_in(3'd0), .cpu_int(m_int), .vec_valid(m_vv), .vec(m_vec),
        .cas_en(m_cen), .cas_id(m_cid));

    irq_ctrl8 #(.IS_MASTER(1'b0)) u_irq_ctrl8_slv (
        .clk(clk), .rst(rst), .wr_en(s_wr), .addr(s_addr), .wdata(s_wdata),
        .rdata(s_rdata), .irq_in(s_irq), .ack(s_ack), .cas_sel(s_sel),
        .cas_in(s_cin), .cpu_int(s_int), .vec_valid(s_vv), .vec(s_vec),
        .cas_en(s_cen), .cas_id(s_cid));

    int checks = 0, fails = 0;
    logic [8:0] exp_q[$];   // {is_cascade, value}

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic mwr(input logic a, input logic [7:0] d);
        @(negedge clk); m_wr = 1; m_addr = a; m_wdata = d;
        @(negedge clk); m_wr = 0; m_addr = 0;
    endtask

    task automatic mrd(input logic a, output logic [7:0] d);
        m_addr = a; #1 d = m_rdata; m_addr = 0;
    endtask

    task automatic mack(input logic [8:0] expv);
        @(negedge clk); exp_q.push_back(expv); m_ack = 1;
        @(negedge clk); m_ack = 0;
    endtask

    task automatic swr(input logic a, input logic [7:0] d);
        @(negedge clk); s_wr = 1; s_addr = a; s_wdata = d;
        @(negedge clk); s_wr = 0; s_addr = 0;
    endtask

    // scoreboard monitor for the master
    always @(negedge clk) begin
        if (!rst && (m_vv || m_cen)) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R12 unexpected output actual=%02h expected=none", m_vec);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R12 kind", {7'd0, m_cen}, {7'd0, e[8]});
                if (e[8]) chk("R10 cascade id", {5'd0, m_cid}, e[7:0]);
                else      chk("R2 vector", m_vec, e[7:0]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 cpu_int", {7'd0, m_int}, 8'h00);
        mrd(1, r); chk("R1 imr", r, 8'h00);
        mrd(0, r); chk("R1 irr read", r, 8'h00);

        // R2 init: base 0x20, slave on input 2, normal end-of-interrupt
        mwr(0, 8'h11); mwr(1, 8'h20); mwr(1, 8'h04); mwr(1, 8'h01);

        // R5 edge sets request, R6 default read is request register
        tick(); m_irq[3] = 1; tick();
        chk("R3 cpu_int on request", {7'd0, m_int}, 8'h01);
        mrd(0, r); chk("R5 irr bit3", r, 8'h08);
        mack({1'b0, 8'h23});
        mrd(0, r); chk("R5 irr cleared by ack", r, 8'h00);
        mwr(0, 8'h0B);
        mrd(0, r); chk("R6 isr read", r, 8'h08);

        // R3 nesting
        m_irq[5] = 1; tick();
        chk("R3 lower blocked", {7'd0, m_int}, 8'h00);
        m_irq[1] = 1; tick();
        chk("R3 higher passes", {7'd0, m_int}, 8'h01);
        mack({1'b0, 8'h21});
        mrd(0, r); chk("R6 isr persists", r, 8'h0A);
        mwr(0, 8'h61);
        mrd(0, r); chk("R7 eoi 1 only", r, 8'h08);
        chk("R3 still blocked", {7'd0, m_int}, 8'h00);
        mwr(0, 8'h63);
        chk("R3 unblocked", {7'd0, m_int}, 8'h01);
        mack({1'b0, 8'h25});
        mwr(0, 8'h65);
        mrd(0, r); chk("R7 isr empty", r, 8'h00);
        m_irq[1] = 0; m_irq[3] = 0; m_irq[5] = 0;
        mwr(0, 8'h0A);
        mrd(0, r); chk("R6 back to irr", r, 8'h00);

        // R4 masking, R8 spurious while masked
        mwr(1, 8'hFF);
        mrd(1, r); chk("R4 imr readback", r, 8'hFF);
        m_irq[0] = 1; tick();
        chk("R4 masked no int", {7'd0, m_int}, 8'h00);
        mack({1'b0, 8'h27});
        mwr(0, 8'h0B);
        mrd(0, r); chk("R8 isr unchanged", r, 8'h00);
        m_irq[0] = 0; tick();
        mwr(1, 8'h00);
        chk("R5 fallen input drops request", {7'd0, m_int}, 8'h00);

        // R8 vanishing request
        m_irq[4] = 1; tick();
        chk("R8 int before vanish", {7'd0, m_int}, 8'h01);
        m_irq[4] = 0; tick();
        chk("R5 vanish clears int", {7'd0, m_int}, 8'h00);
        mack({1'b0, 8'h27});
        mrd(0, r); chk("R8 isr after spurious", r, 8'h00);

        // R10 cascade on input 2
        m_irq[2] = 1; tick();
        mack({1'b1, 8'h02});
        mrd(0, r); chk("R10 isr bit2", r, 8'h04);
        mwr(0, 8'h62); m_irq[2] = 0;
        mrd(0, r); chk("R7 cascade eoi", r, 8'h00);

        // R9 auto end-of-interrupt, reinit base 0x40
        mwr(0, 8'h11); mwr(1, 8'h40); mwr(1, 8'h04); mwr(1, 8'h03);
        mrd(1, r); chk("R2 imr cleared by init", r, 8'h00);
        m_irq[6] = 1; m_irq[7] = 1; tick();
        mack({1'b0, 8'h46});
        mack({1'b0, 8'h47});
        mwr(0, 8'h0B);
        mrd(0, r); chk("R9 no isr bits", r, 8'h00);
        m_irq = 0;

        // R11 slave: identity 2, base 0x70
        swr(0, 8'h11); swr(1, 8'h70); swr(1, 8'h02); swr(1, 8'h01);
        s_irq[4] = 1; tick();
        chk("R11 slave int", {7'd0, s_int}, 8'h01);
        s_ack = 1; s_sel = 1; s_cin = 3'd5; tick();
        s_ack = 0; s_sel = 0;
        chk("R11 wrong id no vector", {7'd0, s_vv}, 8'h00);
        chk("R11 wrong id keeps int", {7'd0, s_int}, 8'h01);
        s_ack = 1; s_sel = 1; s_cin = 3'd2; tick();
        s_ack = 0; s_sel = 0;
        chk("R11 match vector valid", {7'd0, s_vv}, 8'h01);
        chk("R11 match vector", s_vec, 8'h74);

        repeat (3) tick();
        chk("R12 scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule